// File: doc/BRIEF.md
# Exception Vector and Cause Capture

This block gathers the exception requests of a small processor core. Each cycle it picks the most urgent of them and reports the vector offset the core must branch to. Six kinds of request are handled: system reset, machine check, instruction-fetch fault, data-access fault, alignment and external interrupt. Several hardware and translation conditions feed into each kind. Every exception is treated as precise. The block has no imprecise mode.

When a data-access fault is the exception taken, the block also writes a 32-bit status word. The word holds one bit for each reason the access failed, so fault handlers can read why the access was refused. The core samples the inputs on each rising clock edge. One cycle later it sees a one-cycle `vec_valid` pulse together with the chosen offset.

Top module: `exc_vector_unit`

## Requirements
- R1: The offsets produced are 0x00100 for system reset, 0x00200 for machine check, 0x00400 for instruction-fetch fault, 0x00300 for data-access fault, 0x00600 for alignment and 0x00500 for external interrupt. Offset 0x00000 never appears with `vec_valid` high.
- R2: A system reset is raised when `soft_rst_req` or `hard_rst_req` is high.
- R3: A machine check is raised by `mchk_pin`, `addr_par_err` or `data_par_err`. It is also raised by `bus_xfer_err`, but only while `data_bus_busy` is high.
- R4: When several exceptions are raised in one cycle, only one is taken. The order, highest first, is system reset, machine check, instruction-fetch fault, data-access fault, alignment, external interrupt.
- R5: An external interrupt is taken only in a cycle where `irq_pin` and `irq_en` are both 1. While `irq_en` is 0, a held `irq_pin` produces no vector. The interrupt is taken as soon as `irq_en` becomes 1.
- R6: A data-access fault is raised when `dacc_valid` is high together with at least one of `dacc_no_xlat`, `dacc_prot`, `dacc_wt_direct` or `dacc_xctl_off`. Status bit 1 follows `dacc_no_xlat`, bit 4 follows `dacc_prot` and bit 5 follows `dacc_wt_direct`.
- R7: In the status word, bit 6 is 1 for a store and 0 for a load, taken from `dacc_store`. Bit 11 follows `dacc_xctl_off`. Every other bit is always 0.
- R8: The status word is written only in the cycle a data-access fault is taken. If a higher-priority exception wins, or no data fault is taken, the word keeps its value.
- R9: `rst` (synchronous, active high) clears `vec_valid`, `vec_offset` and `dfault_status`. `vec_valid` is high for exactly one cycle per exception taken, in the cycle after the request was sampled.
- R10: An instruction-fetch fault is raised when `ifetch_no_xlat` or `ifetch_prot` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| soft_rst_req | input | 1 | Soft system-reset request |
| hard_rst_req | input | 1 | Hard system-reset request |
| bus_xfer_err | input | 1 | Bus transfer-error strobe |
| data_bus_busy | input | 1 | A data bus transaction is in progress |
| mchk_pin | input | 1 | Machine-check pin |
| addr_par_err | input | 1 | Address parity error |
| data_par_err | input | 1 | Data parity error |
| irq_pin | input | 1 | External interrupt pin |
| irq_en | input | 1 | External interrupt enable |
| ifetch_no_xlat | input | 1 | Fetch address could not be translated |
| ifetch_prot | input | 1 | Fetch forbidden by protection |
| dacc_valid | input | 1 | A data access is checked this cycle |
| dacc_no_xlat | input | 1 | Data translation found no match |
| dacc_prot | input | 1 | Data access forbidden by protection |
| dacc_wt_direct | input | 1 | External-control access to write-through memory, or access to a direct-store segment |
| dacc_store | input | 1 | The data access is a store |
| dacc_xctl_off | input | 1 | External-control access while external access is disabled |
| align_err | input | 1 | Alignment exception request |
| vec_valid | output | 1 | One-cycle pulse: an exception was taken |
| vec_offset | output | 20 | Vector offset of the exception taken |
| dfault_status | output | 32 | Data-access fault status word |

## Verification
Two things can happen in the same cycle. A data-access fault can be raised while a higher-priority cause, such as an instruction-fetch fault or a machine check, is also raised. In that case the offset must be the higher cause's offset and the status word must stay unchanged. The bench provokes this with vector rows that raise both at once, and judges it by comparing the offset and the held status word. It also raises alignment and an enabled interrupt together, and checks that the alignment vector wins.

// File: rtl/exc_vec_pkg.sv
package exc_vec_pkg;
  localparam int VEC_W  = 20;
  localparam int STAT_W = 32;
  localparam int NCAUSE = 6;

  // cause indices in priority order, 0 is most urgent
  localparam int C_RST   = 0;
  localparam int C_MCHK  = 1;
  localparam int C_IFTCH = 2;
  localparam int C_DACC  = 3;
  localparam int C_ALIGN = 4;
  localparam int C_EXT   = 5;

  // status bit positions
  localparam int SB_NOXLAT = 1;
  localparam int SB_PROT   = 4;
  localparam int SB_WTDIR  = 5;
  localparam int SB_STORE  = 6;
  localparam int SB_XCTL   = 11;

  localparam logic [STAT_W-1:0] STAT_MASK =
    (STAT_W'(1) << SB_NOXLAT) | (STAT_W'(1) << SB_PROT) | (STAT_W'(1) << SB_WTDIR) |
    (STAT_W'(1) << SB_STORE)  | (STAT_W'(1) << SB_XCTL);

  function automatic logic [VEC_W-1:0] cause_offset(input int idx);
    case (idx)
      C_RST:   return VEC_W'(20'h00100);
      C_MCHK:  return VEC_W'(20'h00200);
      C_IFTCH: return VEC_W'(20'h00400);
      C_DACC:  return VEC_W'(20'h00300);
      C_ALIGN: return VEC_W'(20'h00600);
      default: return VEC_W'(20'h00500);
    endcase
  endfunction
endpackage

// File: rtl/exc_cause_detect.sv
module exc_cause_detect
  import exc_vec_pkg::*;
#(
  parameter int N = NCAUSE,
  parameter int SW = STAT_W
) (
  input  logic          soft_rst_req,
  input  logic          hard_rst_req,
  input  logic          bus_xfer_err,
  input  logic          data_bus_busy,
  input  logic          mchk_pin,
  input  logic          addr_par_err,
  input  logic          data_par_err,
  input  logic          irq_pin,
  input  logic          irq_en,
  input  logic          ifetch_no_xlat,
  input  logic          ifetch_prot,
  input  logic          dacc_valid,
  input  logic          dacc_no_xlat,
  input  logic          dacc_prot,
  input  logic          dacc_wt_direct,
  input  logic          dacc_store,
  input  logic          dacc_xctl_off,
  input  logic          align_err,
  output logic [N-1:0]  raise,
  output logic [SW-1:0] stat_word
);
  logic dacc_any;

  assign dacc_any = dacc_no_xlat | dacc_prot | dacc_wt_direct | dacc_xctl_off;

  always_comb begin
    raise          = '0;
    raise[C_RST]   = soft_rst_req | hard_rst_req;
    raise[C_MCHK]  = mchk_pin | addr_par_err | data_par_err | (bus_xfer_err & data_bus_busy);
    raise[C_IFTCH] = ifetch_no_xlat | ifetch_prot;
    raise[C_DACC]  = dacc_valid & dacc_any;
    raise[C_ALIGN] = align_err;
    raise[C_EXT]   = irq_pin & irq_en;
  end

  always_comb begin
    stat_word            = '0;
    stat_word[SB_NOXLAT] = dacc_no_xlat;
    stat_word[SB_PROT]   = dacc_prot;
    stat_word[SB_WTDIR]  = dacc_wt_direct;
    stat_word[SB_STORE]  = dacc_store;
    stat_word[SB_XCTL]   = dacc_xctl_off;
  end
endmodule

// File: rtl/exc_prio_sel.sv
module exc_prio_sel
  import exc_vec_pkg::*;
#(
  parameter int N = NCAUSE,
  parameter int VW = VEC_W
) (
  input  logic [N-1:0]  req,
  output logic [N-1:0]  grant,
  output logic          any,
  output logic [VW-1:0] offset
);
  // lower index wins
  logic [N:0] blocked;
  assign blocked[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_chain
    assign grant[i]     = req[i] & ~blocked[i];
    assign blocked[i+1] = blocked[i] | req[i];
  end

  assign any = blocked[N];

  always_comb begin
    offset = '0;
    for (int i = 0; i < N; i++)
      if (grant[i]) offset = offset | VW'(cause_offset(i));
  end
endmodule

// File: rtl/exc_status_reg.sv
module exc_status_reg
  import exc_vec_pkg::*;
#(
  parameter int SW = STAT_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [SW-1:0] d,
  output logic [SW-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)        q <= '0;
    else if (wr_en) q <= d & SW'(STAT_MASK);
  end
endmodule

// File: rtl/exc_vector_unit.sv
module exc_vector_unit
  import exc_vec_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              soft_rst_req,
  input  logic              hard_rst_req,
  input  logic              bus_xfer_err,
  input  logic              data_bus_busy,
  input  logic              mchk_pin,
  input  logic              addr_par_err,
  input  logic              data_par_err,
  input  logic              irq_pin,
  input  logic              irq_en,
  input  logic              ifetch_no_xlat,
  input  logic              ifetch_prot,
  input  logic              dacc_valid,
  input  logic              dacc_no_xlat,
  input  logic              dacc_prot,
  input  logic              dacc_wt_direct,
  input  logic              dacc_store,
  input  logic              dacc_xctl_off,
  input  logic              align_err,
  output logic              vec_valid,
  output logic [VEC_W-1:0]  vec_offset,
  output logic [STAT_W-1:0] dfault_status
);
  logic [NCAUSE-1:0] raise, grant;
  logic [STAT_W-1:0] stat_word;
  logic [VEC_W-1:0]  sel_off;
  logic              take;

  exc_cause_detect #(.N(NCAUSE), .SW(STAT_W)) u_det (
    .soft_rst_req  (soft_rst_req),
    .hard_rst_req  (hard_rst_req),
    .bus_xfer_err  (bus_xfer_err),
    .data_bus_busy (data_bus_busy),
    .mchk_pin      (mchk_pin),
    .addr_par_err  (addr_par_err),
    .data_par_err  (data_par_err),
    .irq_pin       (irq_pin),
    .irq_en        (irq_en),
    .ifetch_no_xlat(ifetch_no_xlat),
    .ifetch_prot   (ifetch_prot),
    .dacc_valid    (dacc_valid),
    .dacc_no_xlat  (dacc_no_xlat),
    .dacc_prot     (dacc_prot),
    .dacc_wt_direct(dacc_wt_direct),
    .dacc_store    (dacc_store),
    .dacc_xctl_off (dacc_xctl_off),
    .align_err     (align_err),
    .raise         (raise),
    .stat_word     (stat_word)
  );

  exc_prio_sel #(.N(NCAUSE), .VW(VEC_W)) u_sel (
    .req   (raise),
    .grant (grant),
    .any   (take),
    .offset(sel_off)
  );

  exc_status_reg #(.SW(STAT_W)) u_stat (
    .clk  (clk),
    .rst  (rst),
    .wr_en(grant[C_DACC]),
    .d    (stat_word),
    .q    (dfault_status)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      vec_valid  <= 1'b0;
      vec_offset <= '0;
    end else begin
      vec_valid <= take;
      if (take) vec_offset <= sel_off;
    end
  end
endmodule

// File: rtl/exc_vector_chk.sv
module exc_vector_chk
  import exc_vec_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              soft_rst_req,
  input logic              hard_rst_req,
  input logic              mchk_pin,
  input logic              addr_par_err,
  input logic              data_par_err,
  input logic              irq_pin,
  input logic              irq_en,
  input logic              ifetch_no_xlat,
  input logic              ifetch_prot,
  input logic              vec_valid,
  input logic [VEC_W-1:0]  vec_offset,
  input logic [STAT_W-1:0] dfault_status
);
  localparam logic [VEC_W-1:0] OFF_RST = VEC_W'(20'h00100);
  localparam logic [VEC_W-1:0] OFF_MCK = VEC_W'(20'h00200);
  localparam logic [VEC_W-1:0] OFF_IFT = VEC_W'(20'h00400);
  localparam logic [VEC_W-1:0] OFF_DAC = VEC_W'(20'h00300);
  localparam logic [VEC_W-1:0] OFF_EXT = VEC_W'(20'h00500);

  AST_NO_RESERVED_VEC: assert property (@(posedge clk) disable iff (rst)
    vec_valid |-> vec_offset != '0);  // R1
  AST_SYSRST_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (soft_rst_req | hard_rst_req) |=> (vec_valid && vec_offset == OFF_RST));  // R2
  AST_MCHK_TAKEN: assert property (@(posedge clk) disable iff (rst)
    ((mchk_pin | addr_par_err | data_par_err) && !soft_rst_req && !hard_rst_req)
      |=> (vec_valid && vec_offset == OFF_MCK));  // R3
  AST_IFETCH_OVER_DACC: assert property (@(posedge clk) disable iff (rst)
    ((ifetch_no_xlat | ifetch_prot) && !soft_rst_req && !hard_rst_req &&
     !mchk_pin && !addr_par_err && !data_par_err)
      |=> (vec_valid && vec_offset == OFF_IFT));  // R4
  AST_EXT_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
    (vec_valid && vec_offset == OFF_EXT) |-> $past(irq_pin && irq_en));  // R5
  AST_STATUS_ZERO_BITS: assert property (@(posedge clk) disable iff (rst)
    (dfault_status & ~STAT_MASK) == '0);  // R7
  AST_STATUS_HELD: assert property (@(posedge clk) disable iff (rst)
    !(vec_valid && vec_offset == OFF_DAC) |-> $stable(dfault_status));  // R8
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!vec_valid && dfault_status == '0));  // R9
endmodule

bind exc_vector_unit exc_vector_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .soft_rst_req  (soft_rst_req),
  .hard_rst_req  (hard_rst_req),
  .mchk_pin      (mchk_pin),
  .addr_par_err  (addr_par_err),
  .data_par_err  (data_par_err),
  .irq_pin       (irq_pin),
  .irq_en        (irq_en),
  .ifetch_no_xlat(ifetch_no_xlat),
  .ifetch_prot   (ifetch_prot),
  .vec_valid     (vec_valid),
  .vec_offset    (vec_offset),
  .dfault_status (dfault_status)
);

// File: tb/sim_exc_vector_unit.sv
`timescale 1ns/1ps
module sim_exc_vector_unit;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [17:0] stim = '0;
  logic vec_valid;
  logic [19:0] vec_offset;
  logic [31:0] dfault_status;
  int n_cmp = 0;
  int n_bad = 0;
  logic [31:0] exp_stat = '0;

  always #2 clk = ~clk;  // 250 MHz

  // stimulus bit positions
  localparam logic [17:0] S_SRES = 18'h20000, S_HRES = 18'h10000, S_XERR = 18'h08000,
    S_BUSY = 18'h04000, S_MCHK = 18'h02000, S_APAR = 18'h01000, S_DPAR = 18'h00800,
    S_IRQ = 18'h00400, S_IEN = 18'h00200, S_IFU = 18'h00100, S_IFP = 18'h00080,
    S_DACC = 18'h00040, S_NOM = 18'h00020, S_PRT = 18'h00010, S_WTD = 18'h00008,
    S_ST = 18'h00004, S_XD = 18'h00002, S_ALN = 18'h00001;

  exc_vector_unit u0 (
    .clk(clk), .rst(rst),
    .soft_rst_req(stim[17]), .hard_rst_req(stim[16]), .bus_xfer_err(stim[15]),
    .data_bus_busy(stim[14]), .mchk_pin(stim[13]), .addr_par_err(stim[12]),
    .data_par_err(stim[11]), .irq_pin(stim[10]), .irq_en(stim[9]),
    .ifetch_no_xlat(stim[8]), .ifetch_prot(stim[7]), .dacc_valid(stim[6]),
    .dacc_no_xlat(stim[5]), .dacc_prot(stim[4]), .dacc_wt_direct(stim[3]),
    .dacc_store(stim[2]), .dacc_xctl_off(stim[1]), .align_err(stim[0]),
    .vec_valid(vec_valid), .vec_offset(vec_offset), .dfault_status(dfault_status)
  );

  // {stimulus, expected offset (0 = nothing taken)}
  localparam int NV = 26;
  localparam logic [37:0] TBL [NV] = '{
    {18'h0,                         20'h00000},
    {S_SRES,                        20'h00100},  // R2
    {S_HRES,                        20'h00100},  // R2
    {S_XERR,                        20'h00000},  // R3 no bus transaction
    {S_XERR|S_BUSY,                 20'h00200},  // R3
    {S_MCHK,                        20'h00200},  // R3
    {S_APAR,                        20'h00200},  // R3
    {S_DPAR,                        20'h00200},  // R3
    {S_IRQ,                         20'h00000},  // R5 masked
    {S_IRQ|S_IEN,                   20'h00500},  // R5
    {S_IFU,                         20'h00400},  // R10
    {S_IFP,                         20'h00400},  // R10
    {S_DACC|S_NOM,                  20'h00300},  // R6
    {S_DACC|S_PRT|S_ST,             20'h00300},  // R6 R7
    {S_DACC|S_WTD,                  20'h00300},  // R6
    {S_DACC|S_XD|S_ST,              20'h00300},  // R7
    {S_NOM,                         20'h00000},  // R6 no access
    {S_DACC,                        20'h00000},  // R6 no reason
    {S_ALN,                         20'h00600},  // R1
    {S_ALN|S_IRQ|S_IEN,             20'h00600},  // R4
    {S_DACC|S_NOM|S_ALN,            20'h00300},  // R4
    {S_IFU|S_DACC|S_PRT,            20'h00400},  // R4 R8
    {S_MCHK|S_IFU|S_DACC|S_NOM,     20'h00200},  // R4 R8
    {S_SRES|S_MCHK|S_IRQ|S_IEN,     20'h00100},  // R4
    {S_DACC|S_NOM|S_PRT|S_WTD|S_ST|S_XD, 20'h00300},  // R6 R7
    {S_IEN,                         20'h00000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] stat_of(input logic [17:0] s);
    logic [31:0] w = '0;
    w[1] = s[5]; w[4] = s[4]; w[5] = s[3]; w[6] = s[2]; w[11] = s[1];
    return w;
  endfunction

  task automatic step(input logic [17:0] s);
    @(negedge clk); stim = s;
    @(negedge clk);
  endtask

  initial begin
    #200000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 reset valid", {31'b0, vec_valid}, 32'h0);
    chk("R9 reset offset", {12'b0, vec_offset}, 32'h0);
    chk("R9 reset status", dfault_status, 32'h0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      logic [17:0] s;
      logic [19:0] eo;
      s  = TBL[i][37:20];
      eo = TBL[i][19:0];
      step(s);
      if (eo == 20'h00300) exp_stat = stat_of(s);
      chk($sformatf("R4 row %0d valid", i), {31'b0, vec_valid}, {31'b0, eo != 0});
      if (eo != 0) chk($sformatf("R1 row %0d offset", i), {12'b0, vec_offset}, {12'b0, eo});
      chk($sformatf("R8 row %0d status", i), dfault_status, exp_stat);
    end

    // R9 single-cycle pulse
    step(S_MCHK);
    chk("R9 pulse high", {31'b0, vec_valid}, 32'h1);
    step(18'h0);
    chk("R9 pulse low", {31'b0, vec_valid}, 32'h0);

    // R5 pending interrupt held while masked, taken once enabled
    for (int k = 0; k < 3; k++) begin
      step(S_IRQ);
      chk("R5 masked hold", {31'b0, vec_valid}, 32'h0);
    end
    step(S_IRQ|S_IEN);
    chk("R5 enabled valid", {31'b0, vec_valid}, 32'h1);
    chk("R5 enabled offset", {12'b0, vec_offset}, 32'h00500);

    // R9 back-to-back takes
    step(S_ALN);
    chk("R9 back-to-back valid", {31'b0, vec_valid}, 32'h1);
    chk("R9 back-to-back offset", {12'b0, vec_offset}, 32'h00600);

    // R9 reset clears status
    step(S_DACC|S_XD);
    chk("R7 bit 11", dfault_status, 32'h00000800);
    @(negedge clk); stim = '0; rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R9 reset clears status", dfault_status, 32'h0);
    chk("R9 reset clears valid", {31'b0, vec_valid}, 32'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule